// File: doc/BRIEF.md
# Configuration-Access Request Engine

This block issues one configuration read or configuration write at a time toward a downstream link. Software programs a small register file: an operation control word (direction and access size), a target word (bus, device, function and byte offset), a write-data word and a timeout limit. It then writes the start bit. The engine builds the request word, the transaction code, a lane-aligned data word and a byte strobe. It presents the request on a valid/ready port and then waits for one pulse on a plain completion port.

When the completion arrives, the engine records the completion status, a non-posted flag and an error flag. It captures read data, drops the busy bit and raises a sticky interrupt bit. Software clears the interrupt bit by writing 1. Unsupported-request and retry completions on a read return fixed data and are not errors; on a write they are errors. Requests to the root bus with a nonzero device number are never sent to the link and complete locally. A programmable timeout aborts a transfer that receives no completion.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, req_valid and irq are 0 and every readable register reads 0, except the timeout limit (index 3), which reads its reset value.
- R2: The transaction code is 0x8 for a read on the root bus and 0x9 for a read elsewhere. It is 0xA for a write on the root bus and 0xB for a write elsewhere. The root bus is the bus equal to the root_bus input.
- R3: req_addr carries bus in [27:20], device in [19:15], function in [14:12] and offset[11:2] in [11:2]. Bits [31:28] and [1:0] are zero. Software writes the target word (index 1) with the same field layout, plus the byte offset in [1:0].
- R4: The control word (index 0) holds the write flag in bit 0 and the size in bits [2:1] (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). req_strb is a run of ones, one per byte, shifted left by offset[1:0] and cut to 4 bits. req_data is the write-data word (index 2) shifted left by 8 times offset[1:0].
- R5: req_valid stays high with stable request fields until a cycle with req_ready high, then drops. Exactly one request is issued per accepted start.
- R6: Writing 1 to bit 0 of index 4 while idle starts a transfer, and index 4 bit 0 reads 1 while it runs. A completion or abort clears that bit and sets irq, which also reads at index 7 bit 0. Writing 1 to index 7 bit 0 clears irq.
- R7: The status word (index 5) holds the completion code in [9:7], the non-posted flag in bit 10 and the error flag in bit 11. For a read completing OK with cpl_err low, the status is 0x400 and index 6 holds cpl_data. OK with cpl_err high sets bit 11.
- R8: On a read, code 1 returns 0xFFFFFFFF and code 2 returns 0xFFFF0001 in index 6, with bit 11 clear. On a write, codes 1 and 2 set bit 11.
- R9: Code 4 and any code other than 0, 1, 2 set bit 11 and leave index 6 unchanged.
- R10: A start written while a transfer is active is ignored. No second request is issued and the active request fields do not change.
- R11: A start to the root bus with a nonzero device number issues no request. It sets irq on the next cycle with status 0. A read then returns 0xFFFFFFFF; a write has no effect.
- R12: If no completion arrives, the transfer aborts on the cycle after the busy bit has been high for limit+1 cycles. The abort clears the busy bit and req_valid, sets irq and sets status 0xC00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register index for reads |
| rd_data | output | 32 | Combinational register read data |
| root_bus | input | 8 | Bus number of the root bus |
| req_valid | output | 1 | Request presented to the link |
| req_ready | input | 1 | Link accepts the request |
| req_type | output | 4 | Transaction code |
| req_addr | output | 32 | Packed configuration address |
| req_data | output | 32 | Lane-aligned write data |
| req_strb | output | 4 | Byte strobe |
| cpl_valid | input | 1 | Completion pulse |
| cpl_status | input | 3 | Completion code |
| cpl_err | input | 1 | Completion error indication |
| cpl_data | input | 32 | Completion read data |
| irq | output | 1 | Sticky transfer-done flag |

## Verification
The bench targets several distinct corner cases:
- Retry and unsupported-request codes, given opposite meaning for reads and writes. A design that decodes them without the direction would either flag harmless probe reads or hide failed writes.
- A second start while busy. If accepted, it would overwrite the request fields or emit a second request.
- A root-bus access with a nonzero device number. A wrong design would push it onto the link.
- A completion that never arrives. The timeout must release the engine on an exact cycle rather than hang it.
- Sub-word writes at odd offsets. These expose strobe and lane shifts taken the wrong way.

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine #(
  parameter int TMO_W = 16,
  parameter logic [TMO_W-1:0] TMO_RST = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic [7:0]  root_bus,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [3:0]  req_type,
  output logic [31:0] req_addr,
  output logic [31:0] req_data,
  output logic [3:0]  req_strb,
  input  logic        cpl_valid,
  input  logic [2:0]  cpl_status,
  input  logic        cpl_err,
  input  logic [31:0] cpl_data,
  output logic        irq
);
  localparam logic [2:0] CS_OK = 3'd0, CS_UR = 3'd1, CS_CRS = 3'd2;

  logic [2:0]       ctrl_q;
  logic [27:0]      tgt_q;
  logic [31:0]      wdat_q, rdat_q;
  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic             busy_q, irq_q, err_q, np_q;
  logic [2:0]       sts_q;

  wire        op_wr    = ctrl_q[0];
  wire [1:0]  sz       = ctrl_q[2:1];
  wire [1:0]  boff     = tgt_q[1:0];
  wire        on_root  = tgt_q[27:20] == root_bus;
  wire        drop     = on_root && (tgt_q[19:15] != 5'd0);
  wire [3:0]  run      = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
  wire [7:0]  run_sh   = {4'b0, run} << boff;
  wire [3:0]  code     = {2'b10, op_wr, ~on_root};
  wire        launch   = wr_en && wr_addr == 3'd4 && wr_data[0] && !busy_q;
  wire        take_cpl = busy_q && !req_valid && cpl_valid;
  wire        cur_wr   = req_type[1];

  logic        bad;
  logic [31:0] sub;
  always_comb begin
    case (cpl_status)
      CS_OK:   begin bad = cpl_err; sub = cpl_data;     end
      CS_UR:   begin bad = cur_wr;  sub = 32'hFFFFFFFF; end
      CS_CRS:  begin bad = cur_wr;  sub = 32'hFFFF0001; end
      default: begin bad = 1'b1;    sub = rdat_q;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; tgt_q <= '0; wdat_q <= '0; rdat_q <= '0;
      tmo_q <= TMO_RST; cnt_q <= '0;
      busy_q <= 1'b0; irq_q <= 1'b0; err_q <= 1'b0; np_q <= 1'b0; sts_q <= '0;
      req_valid <= 1'b0; req_type <= '0; req_addr <= '0; req_data <= '0; req_strb <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: ctrl_q <= wr_data[2:0];
          3'd1: tgt_q  <= wr_data[27:0];
          3'd2: wdat_q <= wr_data;
          3'd3: tmo_q  <= wr_data[TMO_W-1:0];
          3'd7: if (wr_data[0]) irq_q <= 1'b0;
          default: ;
        endcase
      end
      if (launch) begin
        sts_q <= CS_OK;
        err_q <= 1'b0;
        if (drop) begin
          irq_q <= 1'b1;
          np_q  <= 1'b0;
          if (!op_wr) rdat_q <= 32'hFFFFFFFF;
        end else begin
          busy_q    <= 1'b1;
          np_q      <= 1'b1;
          cnt_q     <= '0;
          req_valid <= 1'b1;
          req_type  <= code;
          req_addr  <= {4'b0, tgt_q[27:2], 2'b00};
          req_data  <= wdat_q << {boff, 3'b000};
          req_strb  <= run_sh[3:0];
        end
      end
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (req_valid && req_ready) req_valid <= 1'b0;
        if (take_cpl) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
          sts_q  <= cpl_status;
          err_q  <= bad;
          if (!cur_wr && !bad) rdat_q <= sub;
        end else if (cnt_q == tmo_q) begin
          busy_q    <= 1'b0;
          req_valid <= 1'b0;
          irq_q     <= 1'b1;
          err_q     <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = {29'd0, ctrl_q};
      3'd1: rd_data = {4'd0, tgt_q};
      3'd2: rd_data = wdat_q;
      3'd3: rd_data = 32'(tmo_q);
      3'd4: rd_data = {31'd0, busy_q};
      3'd5: rd_data = {20'd0, err_q, np_q, sts_q, 7'd0};
      3'd6: rd_data = rdat_q;
      default: rd_data = {31'd0, irq_q};
    endcase
  end

  assign irq = irq_q;
endmodule

module cfg_pio_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_q,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_type,
  input logic [3:0] req_strb,
  input logic       irq
);
  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !req_valid);
  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_type[3:2] == 2'b10));
  // R4
  strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_strb != 4'd0);
  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_type)) || !busy_q);
  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> irq);
  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_valid) |=> !req_valid);
endmodule

bind cfg_pio_engine cfg_pio_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_q(busy_q), .req_valid(req_valid),
  .req_ready(req_ready), .req_type(req_type), .req_strb(req_strb), .irq(irq)
);

// File: tb/tb_cfg_pio_engine.sv
module tb_cfg_pio_engine;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [2:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic [2:0] rd_addr = 0; logic [31:0] rd_data;
  logic [7:0] root_bus = 0;
  logic req_valid, req_ready = 1; logic [3:0] req_type, req_strb;
  logic [31:0] req_addr, req_data;
  logic cpl_valid = 0; logic [2:0] cpl_status = 0; logic cpl_err = 0; logic [31:0] cpl_data = 0;
  logic irq;
  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";

  cfg_pio_engine dut (.*);

  always #2 clk = ~clk;

  // behavioural reference model
  int m_ctrl, m_tgt, m_wd, m_rd, m_tmo, m_cnt, m_sts;
  bit m_busy, m_irq, m_err, m_np, m_rv;
  int m_type, m_addr, m_data, m_strb;

  function automatic int mread(int a);
    case (a)
      0: return m_ctrl; 1: return m_tgt; 2: return m_wd; 3: return m_tmo;
      4: return int'(m_busy); 5: return (int'(m_err) << 11) | (int'(m_np) << 10) | (m_sts << 7);
      6: return m_rd; default: return int'(m_irq);
    endcase
  endfunction

  always @(posedge clk) begin
    bit ob, orv; int ocnt, bus, dev, off, sz, nb;
    if (!rst_n) begin
      m_ctrl = 0; m_tgt = 0; m_wd = 0; m_rd = 0; m_tmo = 1000; m_cnt = 0; m_sts = 0;
      m_busy = 0; m_irq = 0; m_err = 0; m_np = 0; m_rv = 0;
      m_type = 0; m_addr = 0; m_data = 0; m_strb = 0;
    end else begin
      ob = m_busy; orv = m_rv; ocnt = m_cnt;
      if (wr_en) begin
        case (wr_addr)
          0: m_ctrl = wr_data & 7;
          1: m_tgt = wr_data & 32'h0FFFFFFF;
          2: m_wd = wr_data;
          3: m_tmo = wr_data & 16'hFFFF;
          7: if (wr_data[0]) m_irq = 0;
          4: if (wr_data[0] && !ob) begin
            bus = (m_tgt >> 20) & 255; dev = (m_tgt >> 15) & 31; off = m_tgt & 3;
            sz = (m_ctrl >> 1) & 3; nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            m_sts = 0; m_err = 0;
            if (bus == root_bus && dev != 0) begin
              m_irq = 1; m_np = 0;
              if (!(m_ctrl & 1)) m_rd = 32'hFFFFFFFF;
            end else begin
              m_busy = 1; m_np = 1; m_cnt = 0; m_rv = 1;
              m_type = ((m_ctrl & 1) ? 10 : 8) + ((bus == root_bus) ? 0 : 1);
              m_addr = m_tgt & 32'h0FFFFFFC;
              m_data = m_wd << (8 * off);
              m_strb = (((1 << nb) - 1) << off) & 15;
            end
          end
          default: ;
        endcase
      end
      if (ob) begin
        m_cnt = ocnt + 1;
        if (orv && req_ready) m_rv = 0;
        if (!orv && cpl_valid) begin
          bit isw, e; int d;
          isw = (m_type == 10 || m_type == 11); d = m_rd;
          if (cpl_status == 0) begin e = cpl_err; d = cpl_data; end
          else if (cpl_status == 1) begin e = isw; d = 32'hFFFFFFFF; end
          else if (cpl_status == 2) begin e = isw; d = 32'hFFFF0001; end
          else e = 1;
          m_busy = 0; m_irq = 1; m_sts = cpl_status; m_err = e;
          if (!isw && !e) m_rd = d;
        end else if (ocnt == m_tmo) begin
          m_busy = 0; m_rv = 0; m_irq = 1; m_err = 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    #1;
    chk({phase, " req_valid"}, 32'(req_valid), 32'(m_rv));
    chk({phase, " irq"}, 32'(irq), 32'(m_irq));
    chk({phase, " rd_data"}, rd_data, mread(int'(rd_addr)));
    if (m_rv) begin
      chk({phase, " req_type"}, 32'(req_type), m_type);
      chk({phase, " req_addr"}, req_addr, m_addr);
      chk({phase, " req_data"}, req_data, m_data);
      chk({phase, " req_strb"}, 32'(req_strb), m_strb);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(int a, output logic [31:0] v);
    rd_addr = 3'(a); #1; v = rd_data;
  endtask

  task automatic cpl(logic [2:0] s, logic e, logic [31:0] d);
    while (req_valid) @(negedge clk);
    @(negedge clk); cpl_valid = 1; cpl_status = s; cpl_err = e; cpl_data = d;
    @(negedge clk); cpl_valid = 0;
  endtask

  task automatic go(int ctrl, int tgt, int wd);
    wr(0, ctrl); wr(1, tgt); wr(2, wd); wr(7, 1); wr(4, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(5, v); chk("R1 status", v, 0);
    peek(6, v); chk("R1 rdata", v, 0);
    peek(3, v); chk("R1 tmo", v, 1000);
    chk("R1 req_valid", 32'(req_valid), 0);

    // R2 R3 R5 R7: read type0 with stalled ready
    phase = "R5"; req_ready = 0;
    go(4, 32'h010, 0);
    chk("R2 type0 read", 32'(req_type), 8);
    chk("R3 addr", req_addr, 32'h10);
    repeat (3) @(negedge clk);
    chk("R5 held", 32'(req_valid), 1);
    req_ready = 1; @(negedge clk);
    chk("R5 dropped", 32'(req_valid), 0);
    peek(4, v); chk("R6 busy", v, 1);
    phase = "R7"; cpl(0, 0, 32'h12345678);
    peek(5, v); chk("R7 status", v, 32'h400);
    peek(6, v); chk("R7 rdata", v, 32'h12345678);
    peek(4, v); chk("R6 idle", v, 0);
    chk("R6 irq set", 32'(irq), 1);
    wr(7, 1); chk("R6 irq clr", 32'(irq), 0);

    // R4 R8: byte write type1 odd offset, UR -> error
    phase = "R4"; go(1, 32'h32A013, 32'hAB);
    chk("R2 type1 write", 32'(req_type), 11);
    chk("R3 addr b3d5f2", req_addr, 32'h32A010);
    chk("R4 strb", 32'(req_strb), 8);
    chk("R4 data", req_data, 32'hAB000000);
    phase = "R8"; cpl(1, 0, 0);
    peek(5, v); chk("R8 wr UR", v, 32'hC80);
    go(4, 32'h200000, 0); cpl(1, 0, 32'h5);
    peek(5, v); chk("R8 rd UR sts", v, 32'h480);
    peek(6, v); chk("R8 rd UR data", v, 32'hFFFFFFFF);
    go(4, 32'h200000, 0); cpl(2, 0, 32'h5);
    peek(5, v); chk("R8 rd CRS sts", v, 32'h500);
    peek(6, v); chk("R8 rd CRS data", v, 32'hFFFF0001);
    phase = "R4"; go(3, 32'h002, 32'h1234);
    chk("R2 type0 write", 32'(req_type), 10);
    chk("R4 strb half", 32'(req_strb), 12);
    chk("R4 data half", req_data, 32'h12340000);
    phase = "R8"; cpl(2, 0, 0);
    peek(5, v); chk("R8 wr CRS", v, 32'hD00);

    // R9 R7 error cases
    phase = "R9"; go(4, 32'h100000, 0); cpl(4, 0, 32'h77);
    peek(5, v); chk("R9 CA", v, 32'hE00);
    peek(6, v); chk("R9 data kept", v, 32'hFFFF0001);
    go(4, 32'h100000, 0); cpl(5, 0, 32'h77);
    peek(5, v); chk("R9 unknown", v, 32'hE80);
    phase = "R7"; go(4, 32'h100000, 0); cpl(0, 1, 32'h77);
    peek(5, v); chk("R7 ok+err", v, 32'hC00);

    // R10 start while busy
    phase = "R10"; req_ready = 0;
    go(4, 32'h100000, 0);
    wr(1, 32'h000010); wr(4, 1);
    chk("R10 type kept", 32'(req_type), 9);
    chk("R10 addr kept", req_addr, 32'h100000);
    req_ready = 1; cpl(0, 0, 32'hCAFE);
    repeat (3) @(negedge clk);
    chk("R10 no second req", 32'(req_valid), 0);

    // R11 local drop
    phase = "R11"; go(4, 32'h018000, 0);
    chk("R11 no req", 32'(req_valid), 0);
    chk("R11 irq", 32'(irq), 1);
    peek(6, v); chk("R11 ones", v, 32'hFFFFFFFF);
    peek(5, v); chk("R11 status", v, 0);
    go(1, 32'h018000, 32'h55);
    chk("R11 wr dropped", 32'(req_valid), 0);

    // R12 timeout
    phase = "R12"; wr(3, 5); go(4, 32'h100000, 0);
    repeat (5) @(negedge clk);
    peek(4, v); chk("R12 still busy", v, 1);
    @(negedge clk);
    peek(4, v); chk("R12 aborted", v, 0);
    peek(5, v); chk("R12 status", v, 32'hC00);
    chk("R12 irq", 32'(irq), 1);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule